// File: doc/BRIEF.md
# Adaptive Flash ECC Policy Controller

This block keeps the wear policy for a flash array whose erase blocks are split into equal groups. Each cycle it may receive one program/erase event pulse, tagged with the group it hit. For every group it keeps a P/E count, a serial rank, a BCH correction-strength level, a retention age and a refresh interval. The group holding rank 0 is the next to be retired to the back of the order. When that group reaches the P/E threshold, it moves to the highest rank, every other rank moves down by one, its code strength steps up, and its retention age restarts at 1.

The retention age rises once per fixed number of P/E events after a group's first renumbering. Once the age is above 1, a countdown timer for the group issues correct-and-refresh request pulses. Each request is held off until the request is acknowledged, and the timer then restarts from the group's current interval. That interval halves after every fixed number of age steps, down to a floor. A combinational query port returns the strength, rank, age and interval of any group by index. The encoder and decoder, and the refresh work itself, live outside this block.

Top module: `flash_wear_policy`

## Requirements
- R1: After reset, group g has rank g, strength T_BASE (10), retention age 0 and interval REFRESH_INIT, and no refresh request is issued.
- R2: A P/E event on the rank-0 group that brings its saturating count to PE_THRESH renumbers the groups. That group takes rank NUM_GROUPS-1 and every other group's rank drops by one in the same clock.
- R3: A group that is not at rank 0 never triggers renumbering. Its count saturates at PE_THRESH. Once it holds rank 0, its next P/E event renumbers at once.
- R4: Renumbering raises the group's strength by T_STEP (10, 12, 14, 16 by default). The strength saturates at T_BASE+T_STEP*(T_LEVELS-1).
- R5: Renumbering sets the group's retention age to 1 and clears its P/E count, so its next threshold needs PE_THRESH fresh events.
- R6: While a group's age is nonzero, every RET_STEP-th P/E event on it adds 1 to the age. The age saturates at 255. A group that has never been renumbered keeps age 0.
- R7: No refresh request is ever issued for a group whose age is 0 or 1.
- R8: When an active group's timer is loaded with interval I, its request pulse appears I+1 clocks later. The pulse lasts one clock, with refresh_group set to the group index. No further request for that group appears until an acknowledge arrives. The acknowledge reloads the timer, so the next pulse follows I+1 clocks after the acknowledge clock.
- R9: Every RET_HALVE age increments halve the group's interval. The interval never falls below REFRESH_MIN. Renumbering restores REFRESH_INIT.
- R10: An acknowledge naming a group with no issued, unacknowledged request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_valid | input | 1 | One P/E event this cycle |
| pe_group | input | $clog2(NUM_GROUPS) | Group hit by the event |
| refresh_ack | input | 1 | Refresh acknowledge strobe |
| ack_group | input | $clog2(NUM_GROUPS) | Group being acknowledged |
| query_group | input | $clog2(NUM_GROUPS) | Group to read back |
| query_strength | output | 8 | Correction strength t of queried group |
| query_rank | output | $clog2(NUM_GROUPS) | Serial rank of queried group |
| query_ret | output | 8 | Retention age of queried group |
| query_interval | output | $clog2(REFRESH_INIT+1) | Refresh interval of queried group |
| refresh_req | output | 1 | One-cycle refresh request pulse |
| refresh_group | output | $clog2(NUM_GROUPS) | Group of the request |

## Verification
A wrong rank register shows as early as the next renumbering: two groups would report rank 0, or the wrong group would be promoted, and the query port shows this one cycle after the event. A stuck or uncleared P/E count shows as a renumber that comes too early or too late, and the rank rotation exposes it within one lap of the groups. Faults in the age or the interval show up on the query port at the event where they happen. Timer faults show in the position of the request pulse relative to the acknowledge, or as a pulse for a group whose age is still 1 or less.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    localparam int RET_W = 8;
    localparam int STR_W = 8;

    typedef logic [RET_W-1:0] ret_t;
    typedef logic [STR_W-1:0] strength_t;
endpackage

// File: rtl/fwp_group_ctrl.sv
module fwp_group_ctrl
    import fwp_pkg::*;
#(
    parameter int NUM_GROUPS   = 8,
    parameter int GROUP_IDX    = 0,
    parameter int PE_THRESH    = 1000,
    parameter int RET_STEP     = 100,
    parameter int RET_HALVE    = 10,
    parameter int REFRESH_INIT = 1000000,
    parameter int REFRESH_MIN  = 1000,
    parameter int T_LEVELS     = 4,
    localparam int RANK_W = $clog2(NUM_GROUPS),
    localparam int CNT_W  = $clog2(PE_THRESH + 1),
    localparam int LVL_W  = $clog2(T_LEVELS),
    localparam int SUB_W  = $clog2(RET_STEP),
    localparam int HLV_W  = $clog2(RET_HALVE),
    localparam int IV_W   = $clog2(REFRESH_INIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pe_hit,
    input  logic              renum_any,
    output logic              renum_self,
    output logic [RANK_W-1:0] rank,
    output logic [LVL_W-1:0]  level,
    output ret_t              ret,
    output logic [IV_W-1:0]   interval
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [RANK_W-1:0] rank;
        logic [LVL_W-1:0]  level;
        ret_t              ret;
        logic [SUB_W-1:0]  sub;
        logic [HLV_W-1:0]  hcnt;
        logic [IV_W-1:0]   interval;
    } grp_state_t;

    grp_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_sat;
    logic [IV_W-1:0]  iv_half;

    // saturating P/E count after the event in flight
    assign cnt_sat    = (st_q.cnt == CNT_W'(PE_THRESH)) ? st_q.cnt : st_q.cnt + 1'b1;
    assign renum_self = pe_hit && (st_q.rank == '0) && (cnt_sat == CNT_W'(PE_THRESH));
    assign iv_half    = ((st_q.interval >> 1) < IV_W'(REFRESH_MIN)) ?
                        IV_W'(REFRESH_MIN) : (st_q.interval >> 1);

    always_comb begin
        st_d = st_q;
        if (renum_any) begin
            if (renum_self) begin
                st_d.rank     = RANK_W'(NUM_GROUPS - 1);
                st_d.cnt      = '0;
                st_d.level    = (st_q.level == LVL_W'(T_LEVELS - 1)) ? st_q.level : st_q.level + 1'b1;
                st_d.ret      = ret_t'(1);
                st_d.sub      = '0;
                st_d.hcnt     = '0;
                st_d.interval = IV_W'(REFRESH_INIT);
            end else begin
                st_d.rank = st_q.rank - 1'b1;
            end
        end else if (pe_hit) begin
            st_d.cnt = cnt_sat;
            if (st_q.ret != '0) begin
                if (st_q.sub == SUB_W'(RET_STEP - 1)) begin
                    st_d.sub = '0;
                    if (st_q.ret != '1) begin
                        st_d.ret = st_q.ret + 1'b1;
                        if (st_q.hcnt == HLV_W'(RET_HALVE - 1)) begin
                            st_d.hcnt     = '0;
                            st_d.interval = iv_half;
                        end else begin
                            st_d.hcnt = st_q.hcnt + 1'b1;
                        end
                    end
                end else begin
                    st_d.sub = st_q.sub + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.rank     <= RANK_W'(GROUP_IDX);
            st_q.interval <= IV_W'(REFRESH_INIT);
        end else begin
            st_q <= st_d;
        end
    end

    assign rank     = st_q.rank;
    assign level    = st_q.level;
    assign ret      = st_q.ret;
    assign interval = st_q.interval;
endmodule

// File: rtl/fwp_refresh_timer.sv
module fwp_refresh_timer #(
    parameter int IV_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            renum,
    input  logic [IV_W-1:0] reload_val,
    input  logic            ack_hit,
    input  logic            sent_set,
    output logic            pending,
    output logic            sent
);
    typedef struct packed {
        logic [IV_W-1:0] timer;
        logic            pending;
        logic            sent;
    } tmr_state_t;

    tmr_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (renum || !active) begin
            st_d.timer   = reload_val;
            st_d.pending = 1'b0;
            st_d.sent    = 1'b0;
        end else if (st_q.pending) begin
            if (st_q.sent && ack_hit) begin
                st_d.pending = 1'b0;
                st_d.sent    = 1'b0;
                st_d.timer   = reload_val;
            end else if (sent_set) begin
                st_d.sent = 1'b1;
            end
        end else if (st_q.timer <= IV_W'(1)) begin
            st_d.pending = 1'b1;
        end else begin
            st_d.timer = st_q.timer - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pending;
    assign sent    = st_q.sent;
endmodule

// File: rtl/fwp_req_arbiter.sv
module fwp_req_arbiter #(
    parameter int NUM_GROUPS = 8,
    localparam int GW = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS-1:0] cand,
    output logic                  grant_valid,
    output logic [GW-1:0]         grant_idx,
    output logic [NUM_GROUPS-1:0] grant_vec
);
    always_comb begin
        grant_idx = '0;
        grant_vec = '0;
        for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant_idx = GW'(i);
            end
        end
        grant_valid = |cand;
        if (grant_valid) begin
            grant_vec[grant_idx] = 1'b1;
        end
    end
endmodule

// File: rtl/flash_wear_policy.sv
module flash_wear_policy
    import fwp_pkg::*;
#(
    parameter int NUM_GROUPS   = 8,
    parameter int PE_THRESH    = 1000,
    parameter int RET_STEP     = 100,
    parameter int RET_HALVE    = 10,
    parameter int REFRESH_INIT = 1000000,
    parameter int REFRESH_MIN  = 1000,
    parameter int T_BASE       = 10,
    parameter int T_STEP       = 2,
    parameter int T_LEVELS     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pe_valid,
    input  logic [$clog2(NUM_GROUPS)-1:0]     pe_group,
    input  logic                              refresh_ack,
    input  logic [$clog2(NUM_GROUPS)-1:0]     ack_group,
    input  logic [$clog2(NUM_GROUPS)-1:0]     query_group,
    output logic [7:0]                        query_strength,
    output logic [$clog2(NUM_GROUPS)-1:0]     query_rank,
    output logic [7:0]                        query_ret,
    output logic [$clog2(REFRESH_INIT+1)-1:0] query_interval,
    output logic                              refresh_req,
    output logic [$clog2(NUM_GROUPS)-1:0]     refresh_group
);
    localparam int GW    = $clog2(NUM_GROUPS);
    localparam int LVL_W = $clog2(T_LEVELS);
    localparam int IV_W  = $clog2(REFRESH_INIT + 1);

    typedef struct packed {
        logic          req;
        logic [GW-1:0] grp;
    } out_state_t;

    logic [NUM_GROUPS-1:0]            pe_hit_vec, ack_hit_vec, renum_vec;
    logic [NUM_GROUPS-1:0]            pend_vec, sent_vec, cand_vec, grant_vec;
    logic [NUM_GROUPS-1:0][GW-1:0]    rank_all;
    logic [NUM_GROUPS-1:0][LVL_W-1:0] level_all;
    logic [NUM_GROUPS-1:0][7:0]       ret_all;
    logic [NUM_GROUPS-1:0][IV_W-1:0]  interval_all;
    logic                             renum_any;
    logic                             grant_valid;
    logic [GW-1:0]                    grant_idx;
    out_state_t                       out_q, out_d;

    assign renum_any = |renum_vec;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        ret_t ret_w;

        assign pe_hit_vec[g]  = pe_valid && (pe_group == GW'(g));
        assign ack_hit_vec[g] = refresh_ack && (ack_group == GW'(g));
        assign ret_all[g]     = ret_w;
        // a group being renumbered this clock must not be granted
        assign cand_vec[g]    = pend_vec[g] && !sent_vec[g] && !renum_vec[g];

        fwp_group_ctrl #(
            .NUM_GROUPS  (NUM_GROUPS),
            .GROUP_IDX   (g),
            .PE_THRESH   (PE_THRESH),
            .RET_STEP    (RET_STEP),
            .RET_HALVE   (RET_HALVE),
            .REFRESH_INIT(REFRESH_INIT),
            .REFRESH_MIN (REFRESH_MIN),
            .T_LEVELS    (T_LEVELS)
        ) i_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .pe_hit    (pe_hit_vec[g]),
            .renum_any (renum_any),
            .renum_self(renum_vec[g]),
            .rank      (rank_all[g]),
            .level     (level_all[g]),
            .ret       (ret_w),
            .interval  (interval_all[g])
        );

        fwp_refresh_timer #(
            .IV_W(IV_W)
        ) i_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (ret_w > ret_t'(1)),
            .renum     (renum_vec[g]),
            .reload_val(interval_all[g]),
            .ack_hit   (ack_hit_vec[g]),
            .sent_set  (grant_vec[g]),
            .pending   (pend_vec[g]),
            .sent      (sent_vec[g])
        );
    end

    fwp_req_arbiter #(
        .NUM_GROUPS(NUM_GROUPS)
    ) i_arb (
        .cand       (cand_vec),
        .grant_valid(grant_valid),
        .grant_idx  (grant_idx),
        .grant_vec  (grant_vec)
    );

    always_comb begin
        out_d     = out_q;
        out_d.req = grant_valid;
        out_d.grp = grant_valid ? grant_idx : out_q.grp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        query_strength = '0;
        query_rank     = '0;
        query_ret      = '0;
        query_interval = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (query_group == GW'(g)) begin
                query_strength = strength_t'(T_BASE) + strength_t'(T_STEP) * strength_t'(level_all[g]);
                query_rank     = rank_all[g];
                query_ret      = ret_all[g];
                query_interval = interval_all[g];
            end
        end
    end

    assign refresh_req   = out_q.req;
    assign refresh_group = out_q.grp;
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
    parameter int NUM_GROUPS   = 8,
    parameter int REFRESH_INIT = 1000000,
    parameter int REFRESH_MIN  = 1000,
    parameter int T_LEVELS     = 4,
    localparam int GW    = $clog2(NUM_GROUPS),
    localparam int LVL_W = $clog2(T_LEVELS),
    localparam int IV_W  = $clog2(REFRESH_INIT + 1)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             refresh_req,
    input logic [GW-1:0]                    refresh_group,
    input logic [NUM_GROUPS-1:0][GW-1:0]    rank_all,
    input logic [NUM_GROUPS-1:0][LVL_W-1:0] level_all,
    input logic [NUM_GROUPS-1:0][7:0]       ret_all,
    input logic [NUM_GROUPS-1:0][IV_W-1:0]  interval_all
);
    logic [NUM_GROUPS-1:0] at_front;

    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            at_front[g] = (rank_all[g] == '0);
        end
    end

    // R2
    single_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(at_front));

    // R7
    refresh_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> (ret_all[refresh_group] > 8'd1));

    // R8
    refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !(refresh_req && (refresh_group == $past(refresh_group))));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        // R4
        level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            level_all[g] >= $past(level_all[g]));

        // R9
        interval_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (interval_all[g] >= IV_W'(REFRESH_MIN)) && (interval_all[g] <= IV_W'(REFRESH_INIT)));
    end
endmodule

bind flash_wear_policy fwp_checker #(
    .NUM_GROUPS  (NUM_GROUPS),
    .REFRESH_INIT(REFRESH_INIT),
    .REFRESH_MIN (REFRESH_MIN),
    .T_LEVELS    (T_LEVELS)
) i_fwp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_req  (refresh_req),
    .refresh_group(refresh_group),
    .rank_all     (rank_all),
    .level_all    (level_all),
    .ret_all      (ret_all),
    .interval_all (interval_all)
);

// File: tb/test_flash_wear_policy.sv
module test_flash_wear_policy;
    localparam int N    = 4;
    localparam int PE_T = 8;
    localparam int RS   = 3;
    localparam int RH   = 2;
    localparam int INIT = 40;
    localparam int MINV = 6;
    localparam int TB   = 10;
    localparam int TS   = 2;
    localparam int TL   = 4;
    localparam int GW   = $clog2(N);
    localparam int IVW  = $clog2(INIT + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pe_valid = 1'b0;
    logic [GW-1:0]  pe_group = '0;
    logic           dir_ack = 1'b0, auto_ack_v = 1'b0, auto_ack = 1'b0;
    logic [GW-1:0]  dir_grp = '0, auto_grp = '0;
    logic [GW-1:0]  query_group = '0;
    logic [7:0]     query_strength, query_ret;
    logic [GW-1:0]  query_rank, refresh_group;
    logic [IVW-1:0] query_interval;
    logic           refresh_req;

    int n_checks = 0, n_err = 0, req_seen = 0, cyc = 0;
    int m_cnt[N], m_rank[N], m_lvl[N], m_ret[N], m_sub[N], m_h[N], m_iv[N];

    always #5 clk = ~clk;

    flash_wear_policy #(
        .NUM_GROUPS(N), .PE_THRESH(PE_T), .RET_STEP(RS), .RET_HALVE(RH),
        .REFRESH_INIT(INIT), .REFRESH_MIN(MINV), .T_BASE(TB), .T_STEP(TS), .T_LEVELS(TL)
    ) i_flash_wear_policy (
        .clk(clk), .rst_n(rst_n), .pe_valid(pe_valid), .pe_group(pe_group),
        .refresh_ack(dir_ack | auto_ack_v), .ack_group(dir_ack ? dir_grp : auto_grp),
        .query_group(query_group), .query_strength(query_strength), .query_rank(query_rank),
        .query_ret(query_ret), .query_interval(query_interval),
        .refresh_req(refresh_req), .refresh_group(refresh_group)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int g = 0; g < N; g++) begin
            m_cnt[g] = 0; m_rank[g] = g; m_lvl[g] = 0; m_ret[g] = 0;
            m_sub[g] = 0; m_h[g] = 0; m_iv[g] = INIT;
        end
    endfunction

    function automatic void model_pe(input int g);
        int sat;
        sat = (m_cnt[g] == PE_T) ? PE_T : m_cnt[g] + 1;
        if (m_rank[g] == 0 && sat == PE_T) begin
            for (int k = 0; k < N; k++) if (k != g) m_rank[k] = m_rank[k] - 1;
            m_rank[g] = N - 1; m_cnt[g] = 0;
            m_lvl[g]  = (m_lvl[g] == TL - 1) ? m_lvl[g] : m_lvl[g] + 1;
            m_ret[g]  = 1; m_sub[g] = 0; m_h[g] = 0; m_iv[g] = INIT;
        end else begin
            m_cnt[g] = sat;
            if (m_ret[g] != 0) begin
                if (m_sub[g] == RS - 1) begin
                    m_sub[g] = 0;
                    if (m_ret[g] != 255) begin
                        m_ret[g]++;
                        if (m_h[g] == RH - 1) begin
                            m_h[g]  = 0;
                            m_iv[g] = (m_iv[g] / 2 < MINV) ? MINV : m_iv[g] / 2;
                        end else m_h[g]++;
                    end
                end else m_sub[g]++;
            end
        end
    endfunction

    function automatic int model_front();
        int f = 0;
        for (int g = 0; g < N; g++) if (m_rank[g] == 0) f = g;
        return f;
    endfunction

    task automatic do_pe(input int g);
        @(negedge clk);
        pe_valid = 1'b1; pe_group = GW'(g);
        @(posedge clk);
        model_pe(g);
        @(negedge clk);
        pe_valid = 1'b0;
    endtask

    task automatic check_group(input int g, input string tag);
        query_group = GW'(g);
        #1;
        chk({tag, " strength"}, int'(query_strength), TB + TS * m_lvl[g]);
        chk({tag, " rank"}, int'(query_rank), m_rank[g]);
        chk({tag, " ret"}, int'(query_ret), m_ret[g]);
        chk({tag, " interval"}, int'(query_interval), m_iv[g]);
    endtask

    task automatic check_all(input string tag);
        for (int g = 0; g < N; g++) check_group(g, tag);
    endtask

    task automatic do_ack(input int g);
        @(negedge clk);
        dir_ack = 1'b1; dir_grp = GW'(g);
        @(posedge clk);
        @(negedge clk);
        dir_ack = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (refresh_req) break;
        end
    endtask

    // request monitor and optional automatic acknowledge
    always @(negedge clk) begin
        auto_ack_v = 1'b0;
        if (rst_n && refresh_req) begin
            req_seen++;
            // R7
            chk("R7 request only for age above 1", int'(m_ret[refresh_group] > 1), 1);
            if (auto_ack) begin
                auto_ack_v = 1'b1;
                auto_grp   = refresh_group;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        int n, seen0, g;
        void'($urandom(32'd20417));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check_all("R1 reset");
        chk("R1 no request after reset", int'(refresh_req), 0);

        // R3: non-front group saturates without renumbering
        repeat (10) do_pe(1);
        check_group(1, "R3 non-front group held");
        check_group(0, "R3 front unchanged");

        // R6: age stays 0 before first renumbering
        repeat (PE_T - 1) do_pe(0);
        check_group(0, "R6 age zero before renumber");
        do_pe(0);
        check_all("R2 R5 renumber");
        query_group = 0; #1;
        chk("R2 promoted rank", int'(query_rank), N - 1);
        chk("R4 strength step", int'(query_strength), 12);
        chk("R5 age set to 1", int'(query_ret), 1);

        // R3: saturated group fires on its first event at the front
        do_pe(1);
        query_group = 1; #1;
        chk("R3 immediate renumber at front", int'(query_rank), N - 1);
        check_all("R3 ranks");

        // R7: age 1 gives no request
        seen0 = req_seen;
        repeat (60) @(negedge clk);
        chk("R7 no request at age 1", req_seen - seen0, 0);

        // R6: age steps every RS events
        repeat (RS - 1) do_pe(0);
        check_group(0, "R6 age before step");
        do_pe(0);
        check_group(0, "R6 age after step");

        // R8: first request I+1 clocks after activation
        wait_req(n);
        chk("R8 first request delay", n, INIT + 1);
        chk("R8 request group", int'(refresh_group), 0);
        @(negedge clk);
        chk("R8 one-cycle pulse", int'(refresh_req), 0);

        // R10: stray acknowledge for another group
        do_ack(2);
        seen0 = req_seen;
        repeat (60) @(negedge clk);
        chk("R10 stray ack ignored", req_seen - seen0, 0);
        chk("R8 no repeat without ack", req_seen - seen0, 0);

        do_ack(0);
        wait_req(n);
        chk("R8 request delay after ack", n, INIT + 1);
        do_ack(0);

        // R9: interval halving and floor
        auto_ack = 1'b1;
        for (int i = 0; i < 30; i++) begin
            do_pe(0);
            check_group(0, "R9 interval track");
        end
        query_group = 0; #1;
        chk("R9 interval floor", int'(query_interval), MINV);

        // R4 R5 R9: rotate through the groups
        for (int r = 0; r < 12; r++) begin
            g = model_front();
            for (int i = 0; i < PE_T + 1; i++) begin
                do_pe(g);
                if (m_rank[g] == N - 1) break;
            end
            check_all("R5 R9 rotation");
        end
        for (int k = 0; k < N; k++) begin
            query_group = GW'(k); #1;
            chk("R4 strength saturates", int'(query_strength), TB + TS * (TL - 1));
        end

        // mixed random traffic
        for (int i = 0; i < 2500; i++) begin
            g = ($urandom % 2 == 0) ? model_front() : int'($urandom % N);
            do_pe(g);
            repeat ($urandom % 3) @(negedge clk);
            check_group(int'($urandom % N), "R2 R6 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule